// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM. It takes the memory from reset to a usable state. It holds the clock enable low while the clock settles, then raises it behind a NOP. It then issues the fixed start-up sequence on the command, bank and address pins: a precharge of all banks; an extended mode write that enables the DLL; a mode write that also resets the DLL; a second precharge of all banks; a run of auto-refresh commands; and a last mode write with the DLL reset bit clear. Each command is spaced from the one before by exactly the minimum gap that the previous command requires.

The burst length, burst type, CAS latency and output driver strength are static configuration inputs, and they are packed into the mode register fields. The block checks the burst and latency codes when the settling wait ends. If either code is reserved, the block does not wake the memory. It raises a configuration error and stays in that state. When the sequence succeeds, `initDone` rises once both the final mode write recovery and the DLL lock wait have elapsed. All gaps and waits are parameters counted in clock cycles.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is applied, and for at least STABLE_CYC cycles after it is released, CKE is 0, the command pins show NOP, and initDone and cfgErr are 0.
- R2: CKE rises exactly once and never falls afterwards. The first cycle with CKE high carries a NOP, and no command other than NOP is ever driven while CKE is low.
- R3: After CKE rises, the commands appear in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, REFRESH_CNT auto-refreshes, and the final mode write. No other command appears.
- R4: Pin encodings as {csN,rasN,casN,weN}: NOP is 0111, precharge-all is 0010, auto-refresh is 0001, and a register write is 0000. Precharge-all drives address bit AP_BIT (8) high with all other address and bank bits 0. Auto-refresh drives address and bank 0.
- R5: The extended mode write drives bank 2'b01 (BA0=1, BA1=0). It drives A0=0 to enable the DLL, A1=cfgDrive[0] and A6=cfgDrive[1], and all other address bits 0.
- R6: Both mode writes drive bank 2'b00. They drive A2..A0=cfgBurstLen, A3=cfgBurstType, A6..A4=cfgCasLat, and A7 and A11..A9 as 0. A8 is 1 on the first mode write and 0 on the final one.
- R7: The cycle distance from one command to the next is exactly TRP_CYC after a precharge-all, TMRD_CYC after any register write, and TRFC_CYC after an auto-refresh.
- R8: Every cycle that carries no command shows NOP (chip select low), including every cycle after initDone.
- R9: initDone rises exactly max(final mode write + TMRD_CYC, DLL-reset mode write + DLL_LOCK_CYC) cycles after the cycle numbering origin, and it stays high.
- R10: Legal burst codes are 001, 010 and 011, plus 111 when cfgBurstType is 0. Legal latency codes are 011, 100 and 101. With any other code, cfgErr rises at the end of the settling wait and stays high, CKE stays 0, no command is issued and initDone stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBurstLen | input | 3 | Burst length code for A2..A0 |
| cfgBurstType | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cfgCasLat | input | 3 | CAS latency code for A6..A4 |
| cfgDrive | input | 2 | Driver strength: bit 0 to A1, bit 1 to A6 of the extended write |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| initDone | output | 1 | Sequence complete |
| cfgErr | output | 1 | Reserved burst or latency code detected |

## Verification
The DLL lock countdown starts at the DLL-reset mode write. The mode-write recovery after the final mode write is timed separately. Both gate initDone, and they can expire in the same cycle. The bench sets DLL_LOCK_CYC equal to the total distance from the DLL-reset write to the end of the final write's recovery, so that both windows close on the same edge. It then requires initDone to rise on exactly that cycle, no earlier and no later, for legal configurations drawn both directed and at random.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PREALL  = 3'd1,
    OP_REFRESH = 3'd2,
    OP_EXTMODE = 3'd3,
    OP_MODEDLL = 3'd4,
    OP_MODEFIN = 3'd5
  } seqOp_e;

  typedef enum logic [1:0] {
    GAP_PRE  = 2'd0,
    GAP_MODE = 2'd1,
    GAP_REF  = 2'd2
  } gapSel_e;

  typedef struct packed {
    seqOp_e  op;
    logic    ckeOn;
    logic    loadGap;
    gapSel_e gapSel;
    logic    decGap;
    logic    startLock;
    logic    doneOn;
    logic    errOn;
  } seqStrobe_t;

  function automatic logic cfgLegal(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    logic blOk;
    logic clOk;
    blOk = (bl == 3'b001) || (bl == 3'b010) || (bl == 3'b011) || ((bl == 3'b111) && !bt);
    clOk = (cl == 3'b011) || (cl == 3'b100) || (cl == 3'b101);
    return blOk && clOk;
  endfunction

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int REFRESH_CNT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gapZero,
  input  logic       lockZero,
  input  logic       cfgOk,
  output seqStrobe_t strobe
);

  localparam int RW = $clog2(REFRESH_CNT + 1);

  typedef enum logic [3:0] {
    S_STABLE, S_CKEUP, S_PRE1, S_EMRS, S_MRSDLL, S_PRE2,
    S_REF, S_MRSFIN, S_GAP, S_LOCK, S_DONE, S_ERR
  } seqState_e;

  seqState_e state, nextState, retState, nextRet;
  logic [RW-1:0] refLeft, nextRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_STABLE;
      retState <= S_STABLE;
      refLeft  <= RW'(REFRESH_CNT);
    end else begin
      state    <= nextState;
      retState <= nextRet;
      refLeft  <= nextRef;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.op    = OP_NOP;
    strobe.gapSel = GAP_PRE;
    strobe.ckeOn = !(state == S_STABLE || state == S_ERR);
    nextState    = state;
    nextRet      = retState;
    nextRef      = refLeft;
    unique case (state)
      S_STABLE: begin
        strobe.decGap = !gapZero;
        if (gapZero) nextState = cfgOk ? S_CKEUP : S_ERR;
      end
      S_CKEUP: nextState = S_PRE1;
      S_PRE1: begin
        strobe.op = OP_PREALL; strobe.loadGap = 1'b1; strobe.gapSel = GAP_PRE;
        nextState = S_GAP; nextRet = S_EMRS;
      end
      S_EMRS: begin
        strobe.op = OP_EXTMODE; strobe.loadGap = 1'b1; strobe.gapSel = GAP_MODE;
        nextState = S_GAP; nextRet = S_MRSDLL;
      end
      S_MRSDLL: begin
        strobe.op = OP_MODEDLL; strobe.loadGap = 1'b1; strobe.gapSel = GAP_MODE;
        strobe.startLock = 1'b1;
        nextState = S_GAP; nextRet = S_PRE2;
      end
      S_PRE2: begin
        strobe.op = OP_PREALL; strobe.loadGap = 1'b1; strobe.gapSel = GAP_PRE;
        nextState = S_GAP; nextRet = S_REF;
      end
      S_REF: begin
        strobe.op = OP_REFRESH; strobe.loadGap = 1'b1; strobe.gapSel = GAP_REF;
        nextState = S_GAP;
        nextRet   = (refLeft == RW'(1)) ? S_MRSFIN : S_REF;
        nextRef   = refLeft - RW'(1);
      end
      S_MRSFIN: begin
        strobe.op = OP_MODEFIN; strobe.loadGap = 1'b1; strobe.gapSel = GAP_MODE;
        nextState = S_LOCK;
      end
      S_GAP: begin
        strobe.decGap = !gapZero;
        if (gapZero) nextState = retState;
      end
      S_LOCK: begin
        strobe.decGap = !gapZero;
        if (gapZero && lockZero) nextState = S_DONE;
      end
      S_DONE: strobe.doneOn = 1'b1;
      S_ERR:  strobe.errOn  = 1'b1;
      default: nextState = S_ERR;
    endcase
  end

  // R3
  refBudget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REF) |-> (refLeft != '0));

endmodule

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int AP_BIT       = 8,
  parameter int STABLE_CYC   = 25000,
  parameter int TRP_CYC      = 3,
  parameter int TRFC_CYC     = 17,
  parameter int TMRD_CYC     = 2,
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgBurstType,
  input  logic [2:0]        cfgCasLat,
  input  logic [1:0]        cfgDrive,
  output logic              gapZero,
  output logic              lockZero,
  output logic              ckeQ,
  output logic              csQ,
  output logic              rasQ,
  output logic              casQ,
  output logic              weQ,
  output logic [BA_W-1:0]   baQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              doneQ,
  output logic              errQ
);

  localparam int M1      = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int M2      = (M1 > TMRD_CYC) ? M1 : TMRD_CYC;
  localparam int GAP_TOP = (M2 > STABLE_CYC) ? M2 : STABLE_CYC;
  localparam int GW      = $clog2(GAP_TOP + 1);
  localparam int LW      = $clog2(DLL_LOCK_CYC + 1);
  localparam logic [GW-1:0] STABLE_LOAD = GW'(STABLE_CYC - 1);
  localparam logic [GW-1:0] PRE_LOAD    = GW'(TRP_CYC - 2);
  localparam logic [GW-1:0] MODE_LOAD   = GW'(TMRD_CYC - 2);
  localparam logic [GW-1:0] REF_LOAD    = GW'(TRFC_CYC - 2);
  localparam logic [LW-1:0] LOCK_LOAD   = LW'(DLL_LOCK_CYC - 2);

  logic [GW-1:0]     gapCnt, gapLoadVal;
  logic [LW-1:0]     lockCnt;
  logic [3:0]        cmdNext;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    unique case (strobe.gapSel)
      GAP_PRE:  gapLoadVal = PRE_LOAD;
      GAP_MODE: gapLoadVal = MODE_LOAD;
      GAP_REF:  gapLoadVal = REF_LOAD;
      default:  gapLoadVal = PRE_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              gapCnt <= STABLE_LOAD;
    else if (strobe.loadGap)                gapCnt <= gapLoadVal;
    else if (strobe.decGap && gapCnt != '0) gapCnt <= gapCnt - GW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                lockCnt <= LOCK_LOAD;
    else if (strobe.startLock) lockCnt <= LOCK_LOAD;
    else if (lockCnt != '0)   lockCnt <= lockCnt - LW'(1);
  end

  assign gapZero  = (gapCnt == '0);
  assign lockZero = (lockCnt == '0);

  always_comb begin
    cmdNext  = 4'b0111;
    baNext   = '0;
    addrNext = '0;
    unique case (strobe.op)
      OP_PREALL: begin
        cmdNext = 4'b0010;
        addrNext[AP_BIT] = 1'b1;
      end
      OP_REFRESH: cmdNext = 4'b0001;
      OP_EXTMODE: begin
        cmdNext     = 4'b0000;
        baNext[0]   = 1'b1;
        addrNext[1] = cfgDrive[0];
        addrNext[6] = cfgDrive[1];
      end
      OP_MODEDLL, OP_MODEFIN: begin
        cmdNext       = 4'b0000;
        addrNext[2:0] = cfgBurstLen;
        addrNext[3]   = cfgBurstType;
        addrNext[6:4] = cfgCasLat;
        addrNext[8]   = (strobe.op == OP_MODEDLL);
      end
      default: cmdNext = 4'b0111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeQ  <= 1'b0;
      {csQ, rasQ, casQ, weQ} <= 4'b0111;
      baQ   <= '0;
      addrQ <= '0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      ckeQ  <= strobe.ckeOn;
      {csQ, rasQ, casQ, weQ} <= cmdNext;
      baQ   <= baNext;
      addrQ <= addrNext;
      doneQ <= strobe.doneOn;
      errQ  <= strobe.errOn;
    end
  end

  // R2
  ckeHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ckeQ) |-> ckeQ);

  // R2
  cmdNeedsCke_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({csQ, rasQ, casQ, weQ} != 4'b0111) |-> ckeQ);

  // R6
  modeLegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({csQ, rasQ, casQ, weQ} == 4'b0000 && baQ == '0)
      |-> (cfgLegal(addrQ[2:0], addrQ[3], addrQ[6:4]) && !addrQ[7]));

  // R9
  lockBeforeDone_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> ($past(lockCnt) == '0));

  // R10
  errQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (!ckeQ && !doneQ));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int AP_BIT       = 8,
  parameter int STABLE_CYC   = 25000,
  parameter int TRP_CYC      = 3,
  parameter int TRFC_CYC     = 17,
  parameter int TMRD_CYC     = 2,
  parameter int DLL_LOCK_CYC = 200,
  parameter int REFRESH_CNT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgBurstType,
  input  logic [2:0]        cfgCasLat,
  input  logic [1:0]        cfgDrive,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              cfgErr
);

  seqStrobe_t strobe;
  logic gapZero, lockZero, cfgOk;

  assign cfgOk = cfgLegal(cfgBurstLen, cfgBurstType, cfgCasLat);

  ddr_init_ctrl #(.REFRESH_CNT(REFRESH_CNT)) ctrl (
    .clk(clk), .rstN(rstN), .gapZero(gapZero), .lockZero(lockZero),
    .cfgOk(cfgOk), .strobe(strobe)
  );

  ddr_init_dp #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .STABLE_CYC(STABLE_CYC),
    .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC),
    .DLL_LOCK_CYC(DLL_LOCK_CYC)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgBurstLen(cfgBurstLen), .cfgBurstType(cfgBurstType),
    .cfgCasLat(cfgCasLat), .cfgDrive(cfgDrive),
    .gapZero(gapZero), .lockZero(lockZero),
    .ckeQ(cke), .csQ(csN), .rasQ(rasN), .casQ(casN), .weQ(weN),
    .baQ(ba), .addrQ(addr), .doneQ(initDone), .errQ(cfgErr)
  );

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

  localparam int STB  = 20;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;
  localparam int REFN = 3;
  localparam int LOCK = TMRD + TRP + REFN * TRFC + TMRD;
  localparam int NCMD = 5 + REFN;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [2:0] cfgBurstLen, cfgCasLat;
  logic cfgBurstType;
  logic [1:0] cfgDrive;
  logic cke, csN, rasN, casN, weN, initDone, cfgErr;
  logic [1:0] ba;
  logic [11:0] addr;

  ddr_init_seq #(
    .STABLE_CYC(STB), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
    .DLL_LOCK_CYC(LOCK), .REFRESH_CNT(REFN)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgBurstLen(cfgBurstLen), .cfgBurstType(cfgBurstType),
    .cfgCasLat(cfgCasLat), .cfgDrive(cfgDrive), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .initDone(initDone), .cfgErr(cfgErr)
  );

  int vectors = 0;
  int misses  = 0;

  // kinds: 1 precharge-all, 2 refresh, 3 mode write, 4 extended write
  int kindArr[16];
  int cycArr[16];
  int addrArr[16];
  int baArr[16];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit legalCfg(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    bit blOk = (bl == 3'd1) || (bl == 3'd2) || (bl == 3'd3) || (bl == 3'd7 && bt == 1'b0);
    bit clOk = (cl == 3'd3) || (cl == 3'd4) || (cl == 3'd5);
    return blOk && clOk;
  endfunction

  function automatic int expKind(input int i);
    if (i == 0 || i == 3) return 1;
    if (i == 1) return 4;
    if (i == 2 || i == NCMD - 1) return 3;
    return 2;
  endfunction

  function automatic int expAddr(input int i, input logic [2:0] bl, input logic bt,
                                 input logic [2:0] cl, input logic [1:0] drv);
    int k = expKind(i);
    int modeBits = int'(bl) | (int'(bt) << 3) | (int'(cl) << 4);
    if (k == 1) return 1 << 8;
    if (k == 2) return 0;
    if (k == 4) return (int'(drv[1]) << 6) | (int'(drv[0]) << 1);
    return (i == 2) ? (modeBits | (1 << 8)) : modeBits;
  endfunction

  function automatic int expGap(input int i);
    int k = expKind(i);
    if (k == 1) return TRP;
    if (k == 2) return TRFC;
    return TMRD;
  endfunction

  function automatic string reqOf(input int k);
    if (k == 4) return "R5 extended write fields";
    if (k == 3) return "R6 mode write fields";
    return "R4 precharge/refresh fields";
  endfunction

  task automatic runOne(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                        input logic [1:0] drv);
    bit legal = legalCfg(bl, bt, cl);
    int nCmd = 0, ckeLow = 0, ckeCyc = -1, ckeCode = -1;
    int badCode = 0, cmdAfterDone = 0, cmdNoCke = 0, doneCyc = -1, doneFell = 0;
    int ckeFell = 0;
    bit sawCke = 0, doneSeen = 0, errSeen = 0;
    cfgBurstLen = bl; cfgBurstType = bt; cfgCasLat = cl; cfgDrive = drv;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cke == 1'b0 && {csN, rasN, casN, weN} == 4'b0111 && !initDone && !cfgErr,
          "R1 reset state", {cke, csN, rasN, casN, weN, initDone, cfgErr}, 7'b0011100);
    rstN = 1'b1;
    for (int c = 1; c <= STB + 150; c++) begin
      int code;
      @(negedge clk);
      code = {csN, rasN, casN, weN};
      if (!cke && !sawCke) ckeLow++;
      if (!cke && sawCke) ckeFell++;
      if (cke && !sawCke) begin sawCke = 1; ckeCyc = c; ckeCode = code; end
      if (code != 4'b0111) begin
        if (code != 4'b0010 && code != 4'b0001 && code != 4'b0000) badCode++;
        if (!cke) cmdNoCke++;
        if (doneSeen) cmdAfterDone++;
        if (nCmd < 16) begin
          kindArr[nCmd] = (code == 4'b0010) ? 1 : (code == 4'b0001) ? 2 :
                          (code == 4'b0000) ? (ba[0] ? 4 : 3) : 0;
          cycArr[nCmd]  = c;
          addrArr[nCmd] = int'(addr);
          baArr[nCmd]   = int'(ba);
        end
        nCmd++;
      end
      if (initDone && !doneSeen) begin doneSeen = 1; doneCyc = c; end
      if (!initDone && doneSeen) doneFell++;
      if (cfgErr) errSeen = 1;
    end
    if (legal) begin
      int expDone;
      check(ckeLow >= STB, "R1 cke low after reset", ckeLow, STB);
      check(sawCke && ckeCode == 7, "R2 first cke-high cycle is NOP", ckeCode, 7);
      check(nCmd > 0 && cycArr[0] > ckeCyc, "R2 NOP precedes first command", cycArr[0], ckeCyc + 1);
      check(cmdNoCke == 0 && ckeFell == 0, "R2 cke stays high", cmdNoCke + ckeFell, 0);
      check(nCmd == NCMD, "R3 command count", nCmd, NCMD);
      for (int i = 0; i < NCMD && i < nCmd; i++) begin
        int k = expKind(i);
        check(kindArr[i] == k, "R3 command order", kindArr[i], k);
        check(addrArr[i] == expAddr(i, bl, bt, cl, drv), reqOf(k), addrArr[i],
              expAddr(i, bl, bt, cl, drv));
        check(baArr[i] == ((k == 4) ? 1 : 0), reqOf(k), baArr[i], (k == 4) ? 1 : 0);
        if (i < NCMD - 1 && i + 1 < nCmd)
          check(cycArr[i+1] - cycArr[i] == expGap(i), "R7 command spacing",
                cycArr[i+1] - cycArr[i], expGap(i));
      end
      check(badCode == 0 && cmdAfterDone == 0, "R8 NOP between commands", badCode + cmdAfterDone, 0);
      if (nCmd == NCMD) begin
        expDone = cycArr[NCMD-1] + TMRD;
        if (cycArr[2] + LOCK > expDone) expDone = cycArr[2] + LOCK;
        check(doneCyc == expDone, "R9 initDone timing", doneCyc, expDone);
      end
      check(doneSeen && doneFell == 0, "R9 initDone stays high", doneFell, 0);
      check(!errSeen, "R10 no error on legal config", int'(errSeen), 0);
    end else begin
      check(errSeen, "R10 error flagged", int'(errSeen), 1);
      check(!sawCke, "R10 cke held low", int'(sawCke), 0);
      check(nCmd == 0, "R10 no command issued", nCmd, 0);
      check(!doneSeen, "R10 initDone stays low", int'(doneSeen), 0);
    end
  endtask

  initial begin
    int seedVal;
    logic [2:0] legalBl[4];
    logic [2:0] legalCl[3];
    legalBl[0] = 3'd1; legalBl[1] = 3'd2; legalBl[2] = 3'd3; legalBl[3] = 3'd7;
    legalCl[0] = 3'd3; legalCl[1] = 3'd4; legalCl[2] = 3'd5;
    rstN = 1'b0;
    cfgBurstLen = 3'd1; cfgBurstType = 1'b0; cfgCasLat = 3'd3; cfgDrive = 2'd0;
    seedVal = $urandom(32'd2024);
    runOne(3'b011, 1'b1, 3'b101, 2'b11);
    runOne(3'b111, 1'b0, 3'b011, 2'b01);
    runOne(3'b111, 1'b1, 3'b100, 2'b10);
    runOne(3'b010, 1'b0, 3'b010, 2'b00);
    runOne(3'b000, 1'b0, 3'b100, 2'b00);
    runOne(3'b001, 1'b1, 3'b100, 2'b10);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] bl = 3'($urandom);
      logic bt = 1'($urandom);
      logic [2:0] cl = 3'($urandom);
      logic [1:0] drv = 2'($urandom);
      if ($urandom % 2 == 0) begin
        bl = legalBl[$urandom % 4];
        cl = legalCl[$urandom % 3];
        if (bl == 3'd7) bt = 1'b0;
      end
      runOne(bl, bt, cl, drv);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 100000);
    misses++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule